// File: doc/BRIEF.md
# Prioritized Interrupt Cause Reporter

This block gathers up to 64 interrupt request lines and turns them into one report for a processor core. Each line has its own detection rule: active-high level, active-low level, rising edge or falling edge. Each line also has a priority of its own. Among the lines that are pending, the block picks the winner and holds its number in a current-cause register. It also drives a six-bit pending field, `ip_o`, which the core places into bits IP[7:2] of its cause register. Bit `ip_o[k]` carries IP[k+2].

Two reporting modes set how the upper pending bits are filled:

- **Original mode.** The upper bits carry the cause number, clipped so that it fits the field. When the internal timer is enabled, IP[7] is given to the timer instead.
- **Compatible mode.** IP[7] belongs to the timer alone. Each of IP[6:3] shows whether one chosen source is pending, and a binding register names that source.

Software changes the configuration through a single-cycle write port. A write to the edge-clear address drops edge latches through two source slots. Each slot has its own enable bit.

A two-state report machine has the states `RPT_IDLE` and `RPT_ACTIVE`. It moves from `RPT_IDLE` to `RPT_ACTIVE` (transition RAISE) when a source that is not masked is pending. It moves back (transition DROP) when none is pending. While in `RPT_ACTIVE`, it reloads the cause each cycle (transition UPDATE). In `RPT_IDLE` with nothing pending, it stays where it is (transition REST).

Top module: `irq_cause_reporter`

## Requirements
- R1: `ip_o[0]` (IP[2]) is 1 exactly when `cause_valid_o` is 1. This holds in both reporting modes. `cause_valid_o` is 1 whenever at least one source with a nonzero priority is pending.
- R2: Original mode with the timer disabled (address 0x00: bit0=0, bit1=1). Here `ip_o[5:1]` equals the cause, and any cause of 31 or more reads as 31. The timer input has no effect.
- R3: Source i is reported as cause i when i < 31, and as i+1 when i >= 31. The cause value 31 is therefore never reported. While `cause_valid_o` is 0, `cause_o` is 0.
- R4: Compatible mode (address 0x00 bit0=1). `ip_o[5]` equals the timer input when bit1=0, and is 0 when bit1=1.
- R5: Compatible mode. `ip_o[k+1]` for k=0..3 is the detected pending state of the source whose index is stored in binding field k. The fields sit at address 0x02 in bits [6k+2k+5 : 8k], i.e. bits [5:0], [13:8], [21:16] and [29:24]. The pending state is taken before priority masking.
- R6: The timer-disable bit (address 0x00 bit1) takes its value from `boot_tintdis_i` during reset. Software can rewrite it afterwards.
- R7: Source i is configured at address 0x40+i. Bits [1:0] select the detection rule: 00 high level, 01 low level, 10 rising edge, 11 falling edge. Bits [PRIO_W+1:2] hold the priority.
- R8: A level-mode request keeps no state. Its pending state follows the sampled input, and it ends when the input leaves the active level.
- R9: A write to address 0x01 clears edge latches through two slots. Slot A names a source in bits [5:0] and is enabled by bit 6. Slot B names a source in bits [13:8] and is enabled by bit 14. A slot whose enable bit is 0 clears nothing.
- R10: The pending source with the highest priority wins. On equal priority, the lower index wins. A source with priority 0 is never selected.
- R11: Original mode with the timer enabled (bit1=0). `ip_o[5]` follows the timer input, and `ip_o[4:1]` is the cause clipped at 15.
- R12: If an edge and a clear of the same source fall on the same cycle, the latch stays set.
- R13: A change on `src_i` reaches `cause_valid_o`, `cause_o` and `ip_o` after exactly two rising clock edges. A configuration write reaches `ip_o` one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_tintdis_i | input | 1 | Reset value of the timer-disable bit |
| src_i | input | N_SRC | Interrupt request lines |
| timer_irq_i | input | 1 | Internal timer request |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 32 | Write data |
| cause_valid_o | output | 1 | A cause is being reported |
| cause_o | output | CAUSE_W | Current cause number |
| ip_o | output | 6 | Pending field for IP[7:2] |

## Verification
A wrong edge latch shows at the ports two edges later. The cause either lingers after a clear or never appears after a pulse. Either way it is visible once the latch becomes the highest-priority request. A wrong report state or a wrong priority comparison gives a cause number that does not match the arithmetic winner of the driven pattern, so the bench sweeps every pattern of eight sources with tied and masked priorities. A wrong mode or binding register shows as wrong `ip_o` bits one edge after the write, and the bench covers this with a full sweep of the bound sources and the timer.

// File: rtl/irq_rpt_pkg.sv
package irq_rpt_pkg;

    typedef enum logic [1:0] {
        DET_HIGH = 2'b00,
        DET_LOW  = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    typedef enum logic {
        RPT_IDLE   = 1'b0,
        RPT_ACTIVE = 1'b1
    } rpt_state_e;

    localparam int          ADDR_W        = 8;
    localparam logic [7:0]  ADDR_CTRL     = 8'h00;
    localparam logic [7:0]  ADDR_ECLR     = 8'h01;
    localparam logic [7:0]  ADDR_BIND     = 8'h02;
    localparam int          ADDR_SRC_BASE = 'h40;
    localparam int          NUM_BIND      = 4;
    localparam int          SEL_W         = 6;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_rpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      src_i,
    input  det_mode_e mode_i,
    input  logic      clr_i,
    output logic      pending_o
);

    logic src_q;
    logic latch_q;
    logic edge_now;
    logic is_level;

    assign is_level = (mode_i == DET_HIGH) || (mode_i == DET_LOW);
    assign edge_now = ((mode_i == DET_RISE) &&  src_i && !src_q) ||
                      ((mode_i == DET_FALL) && !src_i &&  src_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            src_q <= src_i;
            if (is_level)      latch_q <= 1'b0;
            else if (edge_now) latch_q <= 1'b1;
            else if (clr_i)    latch_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (mode_i)
            DET_HIGH: pending_o = src_q;
            DET_LOW:  pending_o = !src_q;
            default:  pending_o = latch_q;
        endcase
    end

    // R12: an edge always sets the latch, even against a clear
    p_edge_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> latch_q);
    // R9: a clear without a competing edge empties the latch
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_now) |=> !latch_q);
    // R8: level rules hold no latch
    p_level_nolatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_level |=> !latch_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_SRC  = 40,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 6
) (
    input  logic [N_SRC-1:0]  req_i,
    input  logic [PRIO_W-1:0] prio_i [N_SRC],
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_p  = '0;
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (prio_i[i] > best_p)) begin
                best_p  = prio_i[i];
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ip_map.sv
module irq_ip_map #(
    parameter int CAUSE_W = 6
) (
    input  logic               compat_i,
    input  logic               tintdis_i,
    input  logic               timer_i,
    input  logic               any_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [3:0]         bound_i,
    output logic [5:0]         ip_o
);

    logic [7:0] cause_x;
    logic [4:0] sat5;
    logic [3:0] sat4;

    assign cause_x = 8'(cause_i);
    assign sat5    = (cause_x > 8'd30) ? 5'd31 : cause_x[4:0];
    assign sat4    = (cause_x > 8'd15) ? 4'd15 : cause_x[3:0];

    always_comb begin
        if (compat_i)
            ip_o = {timer_i && !tintdis_i, bound_i, any_i};
        else if (tintdis_i)
            ip_o = {sat5, any_i};
        else
            ip_o = {timer_i, sat4, any_i};
    end

endmodule

// File: rtl/irq_cause_reporter.sv
module irq_cause_reporter
    import irq_rpt_pkg::*;
#(
    parameter  int N_SRC   = 40,
    parameter  int PRIO_W  = 3,
    localparam int CAUSE_W = $clog2(N_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_tintdis_i,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               timer_irq_i,
    input  logic               wr_en_i,
    input  logic [7:0]         wr_addr_i,
    input  logic [31:0]        wr_data_i,
    output logic               cause_valid_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [5:0]         ip_o
);

    localparam int IDX_W = $clog2(N_SRC);

    logic              compat_q;
    logic              tintdis_q;
    logic [SEL_W-1:0]  bind_q [NUM_BIND];
    det_mode_e         mode_q [N_SRC];
    logic [PRIO_W-1:0] prio_q [N_SRC];
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  clr_hit;
    logic [63:0]       pend_ext;
    logic [3:0]        bound;
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    logic [CAUSE_W-1:0] cause_nx;
    logic [5:0]        ip_nx;
    rpt_state_e        state_q;
    rpt_state_e        state_nx;
    logic              eclr_wr;
    logic              unused_bits;

    assign unused_bits = ^{wr_data_i[31:30], wr_data_i[23:22], wr_data_i[15], wr_data_i[7]};
    assign eclr_wr     = wr_en_i && (wr_addr_i == ADDR_ECLR);

    // control and binding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            compat_q  <= 1'b0;
            tintdis_q <= boot_tintdis_i;
            for (int k = 0; k < NUM_BIND; k++) bind_q[k] <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_CTRL) begin
                compat_q  <= wr_data_i[0];
                tintdis_q <= wr_data_i[1];
            end
            if (wr_addr_i == ADDR_BIND) begin
                for (int k = 0; k < NUM_BIND; k++)
                    bind_q[k] <= wr_data_i[8*k +: SEL_W];
            end
        end
    end

    // per-source configuration and detection
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam logic [7:0] CFG_ADDR = 8'(ADDR_SRC_BASE + i);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[i] <= DET_HIGH;
                prio_q[i] <= '0;
            end else if (wr_en_i && (wr_addr_i == CFG_ADDR)) begin
                mode_q[i] <= det_mode_e'(wr_data_i[1:0]);
                prio_q[i] <= wr_data_i[2 +: PRIO_W];
            end
        end

        assign clr_hit[i] = eclr_wr &&
            ((wr_data_i[6]  && (wr_data_i[5:0]  == SEL_W'(i))) ||
             (wr_data_i[14] && (wr_data_i[13:8] == SEL_W'(i))));

        irq_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[i]),
            .mode_i    (mode_q[i]),
            .clr_i     (clr_hit[i]),
            .pending_o (pend[i])
        );
    end

    irq_prio_pick #(
        .N_SRC  (N_SRC),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req_i   (pend),
        .prio_i  (prio_q),
        .found_o (found),
        .idx_o   (pick_idx)
    );

    // cause numbering skips 31
    assign cause_nx = !found ? '0 :
                      (int'(pick_idx) >= 31) ? CAUSE_W'(int'(pick_idx) + 1) :
                                               CAUSE_W'(pick_idx);

    assign pend_ext = 64'(pend);
    for (genvar k = 0; k < NUM_BIND; k++) begin : g_bind
        assign bound[k] = pend_ext[bind_q[k]];
    end

    irq_ip_map #(.CAUSE_W(CAUSE_W)) u_map (
        .compat_i  (compat_q),
        .tintdis_i (tintdis_q),
        .timer_i   (timer_irq_i),
        .any_i     (found),
        .cause_i   (cause_nx),
        .bound_i   (bound),
        .ip_o      (ip_nx)
    );

    // report state machine: next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RPT_IDLE:   if (found)  state_nx = RPT_ACTIVE;  // RAISE
            RPT_ACTIVE: if (!found) state_nx = RPT_IDLE;    // DROP
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RPT_IDLE;
        else        state_q <= state_nx;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o <= '0;
            ip_o    <= '0;
        end else begin
            unique case (state_nx)
                RPT_IDLE:   cause_o <= '0;
                RPT_ACTIVE: cause_o <= cause_nx;
            endcase
            ip_o <= ip_nx;
        end
    end

    assign cause_valid_o = (state_q == RPT_ACTIVE);

    // R1: IP[2] tracks the report state
    p_ip2_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ip_o[0] == cause_valid_o);
    // R3: cause 31 never reported, idle reads zero
    p_no31_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cause_valid_o |-> (int'(cause_o) != 31));
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_valid_o |-> (cause_o == '0));
    // R2: clipped cause in original mode with timer off
    p_sat31_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!compat_q && tintdis_q) && cause_valid_o) |->
        (int'(ip_o[5:1]) == ((int'(cause_o) > 30) ? 31 : int'(cause_o))));
    // R4: disabled timer never reaches IP[7] in compatible mode
    p_compat_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(compat_q && tintdis_q) |-> !ip_o[5]);
    // R10: a masked source is never the winner
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (prio_q[pick_idx] != '0));

endmodule

// File: tb/irq_cause_reporter_tb.sv
module irq_cause_reporter_tb;

    localparam int CLK_P = 10;
    localparam int N     = 40;
    localparam int CW    = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          boot_tintdis;
    logic [N-1:0]  src;
    logic          timer;
    logic          wr_en;
    logic [7:0]    wr_addr;
    logic [31:0]   wr_data;
    logic          cause_valid;
    logic [CW-1:0] cause;
    logic [5:0]    ip;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    irq_cause_reporter #(.N_SRC(N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .boot_tintdis_i (boot_tintdis),
        .src_i          (src),
        .timer_irq_i    (timer),
        .wr_en_i        (wr_en),
        .wr_addr_i      (wr_addr),
        .wr_data_i      (wr_data),
        .cause_valid_o  (cause_valid),
        .cause_o        (cause),
        .ip_o           (ip)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    function automatic int cause_of(int i);
        return (i < 31) ? i : i + 1;
    endfunction

    function automatic int prio8(int i);
        case (i)
            0: return 3; 1: return 0; 2: return 5; 3: return 5;
            4: return 2; 5: return 7; 6: return 7; default: return 1;
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; boot_tintdis = 1'b1; src = '0; timer = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R3 reset valid", int'(cause_valid), 0);
        chk("R3 reset cause", int'(cause), 0);
        chk("R1 reset ip", int'(ip), 0);
        timer = 1'b1;
        tick(2);
        chk("R6 boot strap disables timer", int'(ip), 0);

        // R2 R3 R11 R8: every source alone
        for (int i = 0; i < N; i++) begin
            int c;
            c = cause_of(i);
            wr(8'(8'h40 + i), 32'(1 << 2));
            src = '0; src[i] = 1'b1; timer = i[0];
            tick(2);
            chk("R1 any pending", int'(cause_valid), 1);
            chk("R3 cause number", int'(cause), c);
            chk("R2 saturated ip", int'(ip), ((c > 30 ? 31 : c) << 1) | 1);
            wr(8'h00, 32'h0);
            tick(1);
            chk("R11 timer enabled ip", int'(ip),
                (int'(timer) << 5) | ((c > 15 ? 15 : c) << 1) | 1);
            wr(8'h00, 32'h2);
            src = '0;
            tick(2);
            chk("R8 level released", int'(cause_valid), 0);
            chk("R2 timer ignored idle", int'(ip), 0);
            wr(8'(8'h40 + i), 32'h0);
        end
        timer = 1'b0;

        // R10: all patterns of eight sources
        for (int k = 0; k < 8; k++) wr(8'(8'h40 + k), 32'(prio8(k) << 2));
        for (int p = 0; p < 256; p++) begin
            int bp, bi;
            bp = 0; bi = -1;
            src = '0; src[7:0] = 8'(p);
            tick(2);
            for (int k = 0; k < 8; k++)
                if (p[k] && prio8(k) > bp) begin bp = prio8(k); bi = k; end
            chk("R10 valid", int'(cause_valid), (bi >= 0) ? 1 : 0);
            chk("R10 winner", int'(cause), (bi >= 0) ? bi : 0);
        end
        src = '0;
        for (int k = 0; k < 8; k++) wr(8'(8'h40 + k), 32'h0);
        tick(2);

        // R7 R9 R12: edge rules
        wr(8'h43, 32'((4 << 2) | 2));
        src[33] = 1'b1;
        tick(2);
        wr(8'(8'h40 + 33), 32'((2 << 2) | 3));
        tick(2);
        chk("R7 falling without edge", int'(cause_valid), 0);
        src[3] = 1'b1; tick(1); src[3] = 1'b0;
        tick(2);
        chk("R7 rising latched", int'(cause), 3);
        src[33] = 1'b0;
        tick(2);
        chk("R10 higher prio holds", int'(cause), 3);
        wr(8'h01, 32'((1 << 14) | (33 << 8) | 3));
        tick(2);
        chk("R9 disabled slot ignored", int'(cause), 3);
        wr(8'h01, 32'((1 << 6) | 3));
        tick(2);
        chk("R9 both latches cleared", int'(cause_valid), 0);
        src[3] = 1'b1; tick(1); src[3] = 1'b0;
        tick(2);
        chk("R7 rising latched again", int'(cause), 3);
        wr(8'h01, 32'((1 << 6) | 3));
        src[3] = 1'b0;
        tick(2);
        chk("R9 cleared before race", int'(cause_valid), 0);
        wr_en = 1'b1; wr_addr = 8'h01; wr_data = 32'((1 << 6) | 3); src[3] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick(2);
        chk("R12 edge beats clear", int'(cause_valid), 1);
        chk("R12 edge beats clear cause", int'(cause), 3);
        wr(8'h01, 32'((1 << 6) | 3));
        tick(2);
        chk("R9 slot A clears", int'(cause_valid), 0);
        src = '0;
        wr(8'h43, 32'h0);
        wr(8'(8'h40 + 33), 32'h0);

        // R4 R5: compatible mode
        wr(8'h45, 32'(1 << 2));
        wr(8'(8'h40 + 36), 32'(1 << 2));
        wr(8'h4C, 32'(1 << 2));
        wr(8'h02, 32'((5 << 24) | (12 << 16) | (36 << 8) | 5));
        wr(8'h00, 32'h1);
        for (int m = 0; m < 16; m++) begin
            src = '0; src[5] = m[0]; src[36] = m[1]; src[12] = m[2]; timer = m[3];
            tick(2);
            chk("R5 R4 compat ip", int'(ip),
                (int'(m[3]) << 5) | (int'(m[0]) << 4) | (int'(m[2]) << 3) |
                (int'(m[1]) << 2) | (int'(m[0]) << 1) | int'(m[2:0] != 0));
        end
        wr(8'h00, 32'h3);
        src = '0; src[5] = 1'b1; timer = 1'b1;
        tick(2);
        chk("R4 compat timer disabled", int'(ip), 6'b010011);

        // R13: latency
        wr(8'h00, 32'h2);
        src = '0; timer = 1'b0;
        wr(8'h54, 32'(1 << 2));
        tick(2);
        src[20] = 1'b1;
        tick(1);
        chk("R13 not after one edge", int'(cause_valid), 0);
        tick(1);
        chk("R13 after two edges", int'(cause), 20);

        // R7: low level
        src = '0;
        wr(8'h4A, 32'((3 << 2) | 1));
        tick(2);
        chk("R7 low level pending", int'(cause), 10);
        src[10] = 1'b1;
        tick(2);
        chk("R7 low level released", int'(cause_valid), 0);

        // R6: strap low
        rst_n = 1'b0; boot_tintdis = 1'b0;
        tick(2);
        rst_n = 1'b1; timer = 1'b1; src = '0;
        tick(2);
        chk("R6 strap enables timer", int'(ip), 6'b100000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule